// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor

This block is a small stored-program processor built around one accumulator. It keeps a program counter, an instruction register, the accumulator and a staging register for the second ALU operand. Its add/subtract unit is the only arithmetic. The processor talks to the outside world over a three-bus interface. An address bus selects the location. A data bus carries the value, modelled as a separate input word, an output word and a drive enable. Four strobes select the operation: memory read, memory write, port read and port write.

Every instruction begins with the same three-clock fetch. An execute sequence chosen by the opcode follows, one step per clock. All bus outputs are registered, so each value appears just after the rising edge that performs its step. Memory and port devices answer combinationally while their read strobe is high. The processor captures the data bus on the rising edge that ends that strobe cycle. A write target captures the data on the edge that ends the write-strobe cycle. A halt instruction parks the machine until reset.

Top module: `acc_cpu_core`

## Requirements
- R1: On reset, the program counter and accumulator clear to zero and all strobes, the drive enable and the halted flag are low. The first fetch after reset release reads address 0.
- R2: The fetch spans three clocks. First the program counter appears on the address bus with no strobe. Next, memory read is high with the address held. Then the strobe drops, the word on the data bus enters the instruction register and the program counter increments. Opcode is instruction bits [11:8] and operand is bits [7:0].
- R3: Load (opcode 1) and port input (opcode 5) take three execute clocks: operand address out, then memory read (load) or port read (input), then the accumulator takes the data bus.
- R4: Add (opcode 3) and subtract (opcode 4) take four execute clocks: operand address out, memory read, staging register load, then the accumulator takes its sum with, or difference from, the staged value, modulo 2^12.
- R5: Store (opcode 2) and port output (opcode 6) take three execute clocks. First the operand address goes out. Next the accumulator is driven with no strobe. Then memory write (store) or port write (output) goes high while the data is still driven.
- R6: Jump (opcode 7) loads the operand into the program counter in one execute clock. Jump-if-negative (opcode 8) does the same only when accumulator bit 11 is set, else the next sequential instruction follows.
- R7: No-op (opcode 0) and unused opcodes 10 to 15 take one execute clock with no strobe and no change to the address bus.
- R8: Halt (opcode 9) raises the halted flag one execute clock after its fetch. After that no strobe is asserted, the address bus is frozen and the flag stays high until reset.
- R9: At most one strobe is high in any cycle. The drive enable is high only in the second and third execute clocks of store and port output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| din_i | input | DATA_W | Data bus as driven by memory or a port |
| addr_o | output | ADDR_W | Address bus |
| dout_o | output | DATA_W | Data bus value driven by the processor |
| dout_en_o | output | 1 | Processor drives the data bus |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | Port read strobe |
| io_wr_o | output | 1 | Port write strobe |
| halted_o | output | 1 | Processor has executed a halt |

## Verification
The bench builds the block with DATA_W of 12 and ADDR_W of 8. A 256-word memory therefore covers every operand value, including 0xFF. The 12-bit width lets a subtraction turn the accumulator negative and an addition wrap it back to zero, so both outcomes of jump-if-negative occur. A countdown program runs its loop until the sign bit flips. A second run is cut short by a reset in mid-instruction to show that fetching restarts at address 0.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_NOP = 4'd0;
  localparam logic [OPC_W-1:0] OP_LDA = 4'd1;
  localparam logic [OPC_W-1:0] OP_STA = 4'd2;
  localparam logic [OPC_W-1:0] OP_ADD = 4'd3;
  localparam logic [OPC_W-1:0] OP_SUB = 4'd4;
  localparam logic [OPC_W-1:0] OP_IN  = 4'd5;
  localparam logic [OPC_W-1:0] OP_OUT = 4'd6;
  localparam logic [OPC_W-1:0] OP_JMP = 4'd7;
  localparam logic [OPC_W-1:0] OP_JN  = 4'd8;
  localparam logic [OPC_W-1:0] OP_HLT = 4'd9;

  // Step to be performed at the next rising edge
  typedef enum logic [2:0] {
    ST_F1, ST_F2, ST_F3, ST_E1, ST_E2, ST_E3, ST_E4, ST_HALT
  } step_t;

  typedef struct packed {
    logic io_wr;
    logic io_rd;
    logic mem_wr;
    logic mem_rd;
  } strobe_t;

  // Control word produced by the sequencer for one edge
  typedef struct packed {
    logic    addr_pc;
    logic    addr_opr;
    logic    ir_load;
    logic    pc_inc;
    logic    pc_jump;
    logic    acc_load_bus;
    logic    b_load;
    logic    acc_alu;
    logic    alu_sub;
    logic    drive;
    logic    halt;
    strobe_t strobe;
  } ctl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int W = 12
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y
);

  always_comb begin
    if (sub) y = a - b;
    else     y = a + b;
  end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             acc_neg,
  output ctl_t             ctl
);

  step_t state, state_nxt;

  logic op_mem_in, op_port_in, op_writer, op_operand;

  always_comb begin
    op_mem_in  = (opcode == OP_LDA) || (opcode == OP_ADD) || (opcode == OP_SUB);
    op_port_in = (opcode == OP_IN);
    op_writer  = (opcode == OP_STA) || (opcode == OP_OUT);
    op_operand = op_mem_in || op_port_in || op_writer;
  end

  always_comb begin
    ctl       = '0;
    state_nxt = state;
    case (state)
      ST_F1: begin
        ctl.addr_pc = 1'b1;
        state_nxt   = ST_F2;
      end
      ST_F2: begin
        ctl.strobe.mem_rd = 1'b1;
        state_nxt         = ST_F3;
      end
      ST_F3: begin
        ctl.ir_load = 1'b1;
        ctl.pc_inc  = 1'b1;
        state_nxt   = ST_E1;
      end
      ST_E1: begin
        state_nxt = ST_F1;
        if (op_operand) begin
          ctl.addr_opr = 1'b1;
          state_nxt    = ST_E2;
        end else if (opcode == OP_JMP) begin
          ctl.pc_jump = 1'b1;
        end else if (opcode == OP_JN) begin
          ctl.pc_jump = acc_neg;
        end else if (opcode == OP_HLT) begin
          ctl.halt  = 1'b1;
          state_nxt = ST_HALT;
        end
      end
      ST_E2: begin
        state_nxt = ST_E3;
        if (op_port_in)     ctl.strobe.io_rd  = 1'b1;
        else if (op_writer) ctl.drive         = 1'b1;
        else                ctl.strobe.mem_rd = 1'b1;
      end
      ST_E3: begin
        state_nxt = ST_F1;
        if (opcode == OP_ADD || opcode == OP_SUB) begin
          ctl.b_load = 1'b1;
          state_nxt  = ST_E4;
        end else if (opcode == OP_STA) begin
          ctl.drive         = 1'b1;
          ctl.strobe.mem_wr = 1'b1;
        end else if (opcode == OP_OUT) begin
          ctl.drive        = 1'b1;
          ctl.strobe.io_wr = 1'b1;
        end else begin
          ctl.acc_load_bus = 1'b1;
        end
      end
      ST_E4: begin
        ctl.acc_alu = 1'b1;
        ctl.alu_sub = (opcode == OP_SUB);
        state_nxt   = ST_F1;
      end
      ST_HALT: state_nxt = ST_HALT;
      default: state_nxt = ST_F1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_F1;
    else     state <= state_nxt;
  end

endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] din,
  output logic [OPC_W-1:0]  opcode,
  output logic              acc_neg,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] dout_q,
  output logic              drive_q,
  output strobe_t           strobe_q,
  output logic              halted_q
);

  localparam int SIGN_BIT = DATA_W - 1;
  localparam int OPC_MSB  = DATA_W - 1;

  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] b_q;
  logic [DATA_W-1:0] alu_y;
  logic [ADDR_W-1:0] operand;

  assign operand = ir[ADDR_W-1:0];
  assign opcode  = ir[OPC_MSB -: OPC_W];
  assign acc_neg = acc[SIGN_BIT];

  acc_cpu_alu #(.W(DATA_W)) u_alu (
    .a   (acc),
    .b   (b_q),
    .sub (ctl.alu_sub),
    .y   (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      ir       <= '0;
      acc      <= '0;
      b_q      <= '0;
      addr_q   <= '0;
      dout_q   <= '0;
      drive_q  <= 1'b0;
      strobe_q <= '0;
      halted_q <= 1'b0;
    end else begin
      strobe_q <= ctl.strobe;
      drive_q  <= ctl.drive;
      if (ctl.drive)        dout_q <= acc;
      if (ctl.addr_pc)      addr_q <= pc;
      else if (ctl.addr_opr) addr_q <= operand;
      if (ctl.ir_load)      ir <= din;
      if (ctl.pc_inc)       pc <= pc + 1'b1;
      else if (ctl.pc_jump) pc <= operand;
      if (ctl.acc_load_bus) acc <= din;
      else if (ctl.acc_alu) acc <= alu_y;
      if (ctl.b_load)       b_q <= din;
      if (ctl.halt)         halted_q <= 1'b1;
    end
  end

  // The address bus only moves in cycles that carry no strobe
  assert_addr_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (addr_q != $past(addr_q)) |-> (strobe_q == '0));

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              io_rd_o,
  output logic              io_wr_o,
  output logic              halted_o
);

  ctl_t             ctl;
  logic [OPC_W-1:0] opcode;
  logic             acc_neg;
  strobe_t          strobe;

  acc_cpu_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .opcode  (opcode),
    .acc_neg (acc_neg),
    .ctl     (ctl)
  );

  acc_cpu_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .din      (din_i),
    .opcode   (opcode),
    .acc_neg  (acc_neg),
    .addr_q   (addr_o),
    .dout_q   (dout_o),
    .drive_q  (dout_en_o),
    .strobe_q (strobe),
    .halted_q (halted_o)
  );

  assign mem_rd_o = strobe.mem_rd;
  assign mem_wr_o = strobe.mem_wr;
  assign io_rd_o  = strobe.io_rd;
  assign io_wr_o  = strobe.io_wr;

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    $countones({mem_rd_o, mem_wr_o, io_rd_o, io_wr_o}) <= 1);

  assert_no_drive_on_read_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o || io_rd_o) |-> !dout_en_o);

  assert_write_driven_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_o || io_wr_o) |-> dout_en_o);

  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    halted_o |-> !(mem_rd_o || mem_wr_o || io_rd_o || io_wr_o || dout_en_o));

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    halted_o |=> (halted_o && $stable(addr_o)));

  assert_read_addr_held_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_o) |-> $stable(addr_o));

endmodule

// File: tb/test_acc_cpu_core.sv
`timescale 1ns/1ps
module test_acc_cpu_core;
  localparam int DW    = 12;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  localparam logic [3:0] S_NONE = 4'b0000;
  localparam logic [3:0] S_MRD  = 4'b0001;
  localparam logic [3:0] S_MWR  = 4'b0010;
  localparam logic [3:0] S_IRD  = 4'b0100;
  localparam logic [3:0] S_IWR  = 4'b1000;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [3:0]    stb;
    logic          den;
    logic [DW-1:0] d;
    logic          h;
  } bus_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] din;
  logic [AW-1:0] addr;
  logic [DW-1:0] dout;
  logic          dout_en, mem_rd, mem_wr, io_rd, io_wr, halted;

  always #4 clk = ~clk;

  acc_cpu_core #(.DATA_W(DW), .ADDR_W(AW)) i_acc_cpu_core (
    .clk(clk), .rst(rst), .din_i(din), .addr_o(addr), .dout_o(dout),
    .dout_en_o(dout_en), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .io_rd_o(io_rd), .io_wr_o(io_wr), .halted_o(halted)
  );

  logic [DW-1:0] dmem [DEPTH];
  logic [DW-1:0] rmem [DEPTH];

  function automatic logic [DW-1:0] port_val(input logic [AW-1:0] a);
    return 12'h2A0 ^ {4'h0, a};
  endfunction

  always_comb din = mem_rd ? dmem[addr] : (io_rd ? port_val(addr) : '0);

  always @(posedge clk) if (!rst && mem_wr) dmem[addr] <= dout;

  bus_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic put(input logic [AW-1:0] a, input logic [3:0] s, input logic den,
                     input logic [DW-1:0] d, input logic h, input string t);
    bus_t e;
    e.a = a; e.stb = s; e.den = den; e.d = d; e.h = h;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] v);
    dmem[a] = v;
    rmem[a] = v;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) begin
      dmem[i] = '0;
      rmem[i] = '0;
    end
  endtask

  // Behavioural reference: interprets the program and lists the bus state after every edge
  task automatic build();
    logic [AW-1:0] pc, cur, opr;
    logic [DW-1:0] acc, b, ir;
    logic [3:0]    op;
    bit            stop;
    int            guard;
    pc = '0; acc = '0; stop = 0; guard = 0;
    exp_q.delete();
    tag_q.delete();
    while (!stop && guard < 400) begin
      guard++;
      cur = pc;
      put(cur, S_NONE, 0, 0, 0, "R2");
      put(cur, S_MRD,  0, 0, 0, "R2");
      ir  = rmem[cur];
      pc  = pc + 1'b1;
      put(cur, S_NONE, 0, 0, 0, "R2");
      op  = ir[11:8];
      opr = ir[7:0];
      case (op)
        4'd1, 4'd5: begin
          put(opr, S_NONE, 0, 0, 0, "R3");
          put(opr, (op == 4'd1) ? S_MRD : S_IRD, 0, 0, 0, "R3");
          acc = (op == 4'd1) ? rmem[opr] : port_val(opr);
          put(opr, S_NONE, 0, 0, 0, "R3");
        end
        4'd3, 4'd4: begin
          put(opr, S_NONE, 0, 0, 0, "R4");
          put(opr, S_MRD,  0, 0, 0, "R4");
          b = rmem[opr];
          put(opr, S_NONE, 0, 0, 0, "R4");
          acc = (op == 4'd3) ? acc + b : acc - b;
          put(opr, S_NONE, 0, 0, 0, "R4");
        end
        4'd2, 4'd6: begin
          put(opr, S_NONE, 0, 0, 0, "R5");
          put(opr, S_NONE, 1, acc, 0, "R5");
          put(opr, (op == 4'd2) ? S_MWR : S_IWR, 1, acc, 0, "R5");
          if (op == 4'd2) rmem[opr] = acc;
        end
        4'd7: begin
          pc = opr;
          put(cur, S_NONE, 0, 0, 0, "R6");
        end
        4'd8: begin
          if (acc[11]) pc = opr;
          put(cur, S_NONE, 0, 0, 0, "R6");
        end
        4'd9: begin
          stop = 1;
          for (int k = 0; k < 10; k++) put(cur, S_NONE, 0, 0, 1, "R8");
        end
        default: put(cur, S_NONE, 0, 0, 0, "R7");
      endcase
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({addr, mem_rd, mem_wr, io_rd, io_wr, dout_en, halted} == '0, "R1",
          "reset outputs", {addr, mem_rd, mem_wr, io_rd, io_wr, dout_en, halted}, 0);
    rst = 1'b0;
  endtask

  task automatic play(input int cut);
    bus_t o, e;
    int   n;
    n = exp_q.size();
    if (cut > 0 && cut < n) n = cut;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      e = exp_q[i];
      o.a = addr; o.stb = {io_wr, io_rd, mem_wr, mem_rd}; o.den = dout_en;
      o.d = e.den ? dout : e.d; o.h = halted;
      check(o == e, tag_q[i], $sformatf("bus after edge %0d", i), o, e);
      check($countones(o.stb) <= 1, "R9", "strobe count", o.stb, 0);
      if (i == 0) check(addr == '0, "R1", "first fetch address", addr, 0);
    end
  endtask

  task automatic load_a();
    clear_mem();
    wr(8'h00, 12'h140); wr(8'h01, 12'h341); wr(8'h02, 12'h604); wr(8'h03, 12'h442);
    wr(8'h04, 12'h250); wr(8'h05, 12'h808); wr(8'h06, 12'h900); wr(8'h07, 12'h000);
    wr(8'h08, 12'hC33); wr(8'h09, 12'h517); wr(8'h0A, 12'h806); wr(8'h0B, 12'h000);
    wr(8'h0C, 12'h150); wr(8'h0D, 12'h609); wr(8'h0E, 12'h710); wr(8'h0F, 12'h900);
    wr(8'h10, 12'h343); wr(8'h11, 12'h251); wr(8'h12, 12'h601); wr(8'h13, 12'h900);
    wr(8'h14, 12'h140);
    wr(8'h40, 12'h035); wr(8'h41, 12'h029); wr(8'h42, 12'h100); wr(8'h43, 12'h0A2);
  endtask

  task automatic load_b();
    clear_mem();
    wr(8'h00, 12'h160); wr(8'h01, 12'h461); wr(8'h02, 12'h260); wr(8'h03, 12'h602);
    wr(8'h04, 12'h462); wr(8'h05, 12'h807); wr(8'h06, 12'h701); wr(8'h07, 12'hFFF);
    wr(8'h08, 12'h9FF); wr(8'h09, 12'h160);
    wr(8'h60, 12'h003); wr(8'h61, 12'h001); wr(8'h62, 12'h000);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(8 * 60000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R3 R4 R5 R6 R7 R8: mixed program with taken and untaken jumps, unused opcode, wrap to zero
    load_a(); build(); do_reset(); play(0);
    // R6: countdown loop ending on a negative accumulator, unused opcode 15
    load_b(); build(); do_reset(); play(0);
    // R1: reset in mid-instruction, then a full rerun from address 0
    load_b(); build(); do_reset(); play(23);
    load_b(); build(); do_reset(); play(0);
    done = 1;
    summary();
    $finish;
  end

endmodule